// File: doc/BRIEF.md
# Configurable SPI Slave Channel

A single-channel, three-wire SPI slave. The external master supplies the serial clock, and the slave receives on its data input while it transmits on its data output in the same frame. Software drives the channel through four byte-wide registers. It chooses the clock polarity and phase (the four SPI modes), the bit order, a 7-bit or 8-bit frame, and whether the interrupt marks the end of a frame or the moment the transmit buffer is consumed. A single data address takes the next byte to send and returns the last byte received.

The serial clock and data input pass through a two-flop synchronizer and edge detector running on the system clock. The system clock must run at least four times faster than the serial clock. Frames are delimited by counting bits, since there is no chip-select. Software must load the transmit byte before the master's first clock edge, because the first bit is already driven on the output while the channel is idle. Status flags record a frame that started with nothing loaded (underrun) and a received byte lost before it was read (overrun).

Top module: `spi_slave_chan`

## Requirements
- R1: After reset the registers read as follows: control (address 0) reads 0x04, status (address 2) reads 0x01, run (address 3) reads 0x04, `irq` is low, and `miso` is high.
- R2: Control bit 4 sets the idle clock level. Control bit 3 chooses the sampling edge: 0 samples on the leading edge and shifts on the trailing edge, and 1 does the reverse. In all four modes a frame exchanges the loaded byte for the master's byte, and the received byte reads back at address 1.
- R3: Control bit 1 sets the bit order for both directions: 0 sends MSB first and 1 sends LSB first.
- R4: Control bit 2 sets the frame length: 0 gives 7 bits and 1 gives 8 bits. A 7-bit frame uses data bits 6:0 and reads bit 7 as 0. When the parameter `LEN_SEL` is 0, the frame is always 8 bits.
- R5: A write to address 1 fills the transmit buffer and clears status bit 0 (transmit empty). While the channel is idle, `miso` already carries the first bit of the loaded byte. The byte moves into the shift stage at the first leading edge, and status bit 0 is then set again.
- R6: `irq` is a one-cycle pulse. With control bit 0 at 0 it fires when a frame completes. With control bit 0 at 1 it fires at frame start, when a loaded byte is taken.
- R7: A frame that starts with the buffer empty resends the previously sent byte and sets status bit 3. Writing 1 to status bit 3 clears it.
- R8: A frame that completes while status bit 1 (receive full) is still set sets status bit 2 (overrun) and replaces the stored byte. Reading address 1 clears bit 1, and writing 1 to bit 2 clears bit 2.
- R9: While run bit 1 (output enable) is 0, `miso` holds the level of run bit 2 throughout a frame.
- R10: While run bit 0 (start) is 0, clock edges are ignored. No frame completes and no `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (side effects only) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from `rd_addr` |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| irq | output | 1 | Interrupt pulse |

## Verification
The checker watches several rules on every cycle. `irq` is never longer than one cycle. A transmit-buffer take in buffer-empty mode, and a receive-full rise in completion mode, each come with `irq` in the same cycle. Overrun and underrun rise only from the states that justify them. A disabled channel raises no interrupt, and the bit counter stays inside the selected frame length. The bench scenarios cover the rest: byte exchange in each SPI mode, reversal of bit order, truncation to 7 bits, preloading of the first bit, resending on underrun, gating of the output level, and the fixed-length parameter variant.

// File: rtl/spi_slave_pkg.sv
// Shared definitions for the SPI slave channel: register addresses and
// the layout of the control register. Assumes an 8-bit register bus.
package spi_slave_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DATA = 2'd1,
        A_STAT = 2'd2,
        A_RUN  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       cpol;   // idle clock level
        logic       cpha;   // 1: sample on trailing edge
        logic       len8;   // 1: 8-bit frame, 0: 7-bit frame
        logic       lsb;    // 1: LSB first
        logic       isel;   // 1: interrupt on buffer take
    } ctrl_t;
endpackage

// File: rtl/spi_in_sync.sv
// Two-flop synchronizer for a group of asynchronous inputs.
// Assumes each bit is treated independently and that inputs change
// slowly compared with clk (at least four clk periods per level).
module spi_in_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;
endmodule

// File: rtl/spi_shift_eng.sv
// Bit engine of the SPI slave: detects serial clock edges, counts bits,
// picks the output bit from the current transmit byte and assembles the
// received byte. Frames are bounded by bit count (no chip-select).
// Assumes sck_s and mosi_s are synchronized and aligned with each other.
module spi_shift_eng
    import spi_slave_pkg::*;
#(
    parameter int DW      = 8,
    parameter bit LEN_SEL = 1'b1,
    localparam int CW     = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  ctrl_t         ctrl,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_buf,
    output logic          start_ev,
    output logic          done_ev,
    output logic          busy,
    output logic          miso_bit,
    output logic [DW-1:0] rx_word,
    output logic [CW-1:0] bit_idx,
    output logic [CW:0]   frame_len
);
    logic          sck_d;
    logic          rise, fall, lead, trail, samp_e, shift_e;
    logic          s_ev, sh_ev;
    logic [CW-1:0] k;
    logic [CW-1:0] pos;
    logic [CW:0]   rev_pos;
    logic [DW-1:0] tx_cur, src, rx_acc, rx_next;

    // Frame length: selectable only when the parameter allows it.
    generate
        if (LEN_SEL) begin : g_len_sel
            assign frame_len = ctrl.len8 ? (CW+1)'(DW) : (CW+1)'(DW - 1);
        end else begin : g_len_fix
            assign frame_len = (CW+1)'(DW);
        end
    endgenerate

    // Edge classification relative to the idle level and the phase.
    always_comb begin
        rise    = sck_s & ~sck_d;
        fall    = ~sck_s & sck_d;
        lead    = ctrl.cpol ? fall : rise;
        trail   = ctrl.cpol ? rise : fall;
        samp_e  = ctrl.cpha ? trail : lead;
        shift_e = ctrl.cpha ? lead : trail;
    end

    // Frame events: start, sample, shift and completion.
    always_comb begin
        start_ev = en & ~busy & lead;
        s_ev     = en & (start_ev ? ~ctrl.cpha : (busy & samp_e));
        sh_ev    = en & busy & shift_e;
        k        = busy ? bit_idx : '0;
        rev_pos  = frame_len - (CW+1)'(1) - {1'b0, k};
        pos      = ctrl.lsb ? k : rev_pos[CW-1:0];
        done_ev  = s_ev & ({1'b0, k} == frame_len - (CW+1)'(1));
    end

    // Output bit: idle shows the byte that the next frame will send.
    always_comb begin
        src      = (!busy && tx_full) ? tx_buf : tx_cur;
        miso_bit = src[pos];
    end

    // Receive assembly: clear at frame start, drop the sampled bit in place.
    always_comb begin
        rx_next = start_ev ? '0 : rx_acc;
        if (s_ev) begin
            rx_next[pos] = mosi_s;
        end
        rx_word = rx_next;
    end

    // Frame state, bit counter, current transmit byte and receive register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            busy    <= 1'b0;
            bit_idx <= '0;
            tx_cur  <= '0;
            rx_acc  <= '0;
        end else begin
            sck_d <= sck_s;
            if (!en) begin
                busy    <= 1'b0;
                bit_idx <= '0;
            end else begin
                if (start_ev) begin
                    busy    <= 1'b1;
                    bit_idx <= '0;
                    if (tx_full) begin
                        tx_cur <= tx_buf;
                    end
                end
                if (sh_ev) begin
                    bit_idx <= bit_idx + CW'(1);
                end
                if (done_ev) begin
                    busy    <= 1'b0;
                    bit_idx <= '0;
                end
                if (start_ev || s_ev) begin
                    rx_acc <= rx_next;
                end
            end
        end
    end
endmodule

// File: rtl/spi_slave_chan.sv
// SPI slave channel top: register file, status flags and interrupt,
// around a synchronizer and a bit engine. Assumes clk runs at least four
// times the serial clock rate and that the mode is changed only while the
// channel is stopped. DW must not exceed the 8-bit register width.
module spi_slave_chan
    import spi_slave_pkg::*;
#(
    parameter int DW      = 8,
    parameter bit LEN_SEL = 1'b1,
    localparam int CW     = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             sck,
    input  logic             mosi,
    output logic             miso,
    output logic             irq
);
    ctrl_t         ctrl;
    logic          en, oe, so_lvl;
    logic [DW-1:0] tx_buf, rx_data, rx_word;
    logic          tx_full, rx_full, ovr, udr;
    logic [1:0]    sync_out;
    logic          start_ev, done_ev, busy, miso_bit;
    logic [CW-1:0] bit_idx;
    logic [CW:0]   frame_len;
    logic          wr_ctrl, wr_data_reg, wr_stat, wr_run, rd_data_reg;

    // Decode of bus strobes.
    always_comb begin
        wr_ctrl     = wr_en && (wr_addr == A_CTRL);
        wr_data_reg = wr_en && (wr_addr == A_DATA);
        wr_stat     = wr_en && (wr_addr == A_STAT);
        wr_run      = wr_en && (wr_addr == A_RUN);
        rd_data_reg = rd_en && (rd_addr == A_DATA);
    end

    spi_in_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sck, mosi}),
        .d_out (sync_out)
    );

    spi_shift_eng #(.DW(DW), .LEN_SEL(LEN_SEL)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sck_s     (sync_out[1]),
        .mosi_s    (sync_out[0]),
        .ctrl      (ctrl),
        .tx_full   (tx_full),
        .tx_buf    (tx_buf),
        .start_ev  (start_ev),
        .done_ev   (done_ev),
        .busy      (busy),
        .miso_bit  (miso_bit),
        .rx_word   (rx_word),
        .bit_idx   (bit_idx),
        .frame_len (frame_len)
    );

    // Control and run registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= ctrl_t'(8'h04);
            en     <= 1'b0;
            oe     <= 1'b0;
            so_lvl <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wr_data);
            end
            if (wr_run) begin
                en     <= wr_data[0];
                oe     <= wr_data[1];
                so_lvl <= wr_data[2];
            end
        end
    end

    // Transmit buffer: filled by software, emptied at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else begin
            if (wr_data_reg) begin
                tx_buf <= wr_data[DW-1:0];
            end
            tx_full <= (tx_full && !start_ev) || wr_data_reg;
        end
    end

    // Receive data, receive-full, overrun and underrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
            udr     <= 1'b0;
        end else begin
            if (done_ev) begin
                rx_data <= rx_word;
            end
            rx_full <= done_ev || (rx_full && !rd_data_reg);
            ovr     <= (done_ev && rx_full && !rd_data_reg) ||
                       (ovr && !(wr_stat && wr_data[2]));
            udr     <= (start_ev && !tx_full) ||
                       (udr && !(wr_stat && wr_data[3]));
        end
    end

    // Interrupt pulse from the selected event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= ctrl.isel ? (start_ev && tx_full) : done_ev;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl;
            A_DATA:  rd_data = REG_W'(rx_data);
            A_STAT:  rd_data = {3'b000, busy, udr, ovr, rx_full, ~tx_full};
            default: rd_data = {5'b00000, so_lvl, oe, en};
        endcase
    end

    // Output gate: the fixed level replaces shift data when disabled.
    assign miso = oe ? miso_bit : so_lvl;
endmodule

// File: rtl/spi_slave_chan_chk.sv
// Assertion checker for spi_slave_chan, attached by bind. Observes the
// interrupt, the buffer and status flags, the enable and the bit counter.
module spi_slave_chan_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          isel,
    input logic          tx_full,
    input logic          rx_full,
    input logic          ovr,
    input logic          udr,
    input logic          en,
    input logic [CW-1:0] bit_idx,
    input logic [CW:0]   frame_len
);
    // R6: interrupt lasts a single cycle
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: buffer take in buffer-empty mode raises the interrupt
    p_take_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_full) && $past(isel)) |-> irq);

    // R6: new received byte in completion mode raises the interrupt
    p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && !$past(isel)) |-> irq);

    // R8: overrun only when a byte was still waiting
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_full));

    // R7: underrun only when nothing was loaded
    p_udr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr) |-> !$past(tx_full));

    // R10: a stopped channel raises no interrupt
    p_no_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !irq);

    // R4: bit counter stays within the selected frame length
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, bit_idx} < frame_len);
endmodule

bind spi_slave_chan spi_slave_chan_chk #(.CW($clog2(DW))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .isel      (ctrl.isel),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .ovr       (ovr),
    .udr       (udr),
    .en        (en),
    .bit_idx   (bit_idx),
    .frame_len (frame_len)
);

// File: tb/spi_slave_chan_tb.sv
// Scoreboard bench: the frame driver pushes the byte the slave should
// receive into a queue; the receive monitor task pops and compares it
// against the data register after each frame.
module spi_slave_chan_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, rd_data_f;
    logic       sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_f, irq, irq_f;

    int checks = 0, errors = 0;
    int irq_cnt = 0, mid_irq = 0, oe_bad = 0;
    bit oe_watch = 1'b0, done_flag = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] rv, rvf, mrx;

    always #2 clk = ~clk;

    spi_slave_chan u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    spi_slave_chan #(.LEN_SEL(1'b0)) u_fix (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_f), .sck(sck), .mosi(mosi), .miso(miso_f),
        .irq(irq_f)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (oe_watch && miso !== 1'b1) oe_bad++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rd_data; rvf = rd_data_f;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] ctl, input logic [7:0] run);
        reg_wr(2'd3, run & 8'hFE);
        reg_wr(2'd0, ctl);
        sck = ctl[4]; mosi = 1'b0;
        repeat (6) @(negedge clk);
        reg_wr(2'd3, run);
    endtask

    // Master side of one frame with the given order and length.
    task automatic xfer(input logic [7:0] mtx, input int nb, input logic pol,
                        input logic pha, input logic lsb, output logic [7:0] r);
        r = 8'h00;
        for (int i = 0; i < nb; i++) begin
            automatic int p = lsb ? i : nb - 1 - i;
            if (!pha) begin
                mosi = mtx[p]; half(); sck = ~pol; r[p] = miso; half(); sck = pol;
            end else begin
                sck = ~pol; mosi = mtx[p]; half(); sck = pol; r[p] = miso; half();
            end
            if (i == 0) mid_irq = irq_cnt;
        end
        half();
    endtask

    // Driver: load the slave, push the expected receive byte, run a frame.
    task automatic frame(input logic [7:0] stx, input logic [7:0] mtx, input int nb,
                         input logic pol, input logic pha, input logic lsb,
                         output logic [7:0] r);
        logic [7:0] mask;
        mask = (nb == 7) ? 8'h7F : 8'hFF;
        reg_wr(2'd1, stx);
        exp_q.push_back(mtx & mask);
        xfer(mtx, nb, pol, pha, lsb, r);
    endtask

    // Monitor: pop the expected byte and compare with the data register.
    task automatic check_rx(input string req);
        logic [7:0] e, got;
        e = exp_q.pop_front();
        reg_rd(2'd1, got);
        chk(got == e, req, got, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] stx3[3] = '{8'hC3, 8'h96, 8'hE1};
        logic [7:0] mtx3[3] = '{8'h18, 8'h7E, 8'hA9};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset values
        reg_rd(2'd0, rv); chk(rv == 8'h04, "R1 ctrl", rv, 8'h04);
        reg_rd(2'd2, rv); chk(rv == 8'h01, "R1 stat", rv, 8'h01);
        reg_rd(2'd3, rv); chk(rv == 8'h04, "R1 run", rv, 8'h04);
        chk(miso == 1'b1 && irq == 1'b0, "R1 pins", {miso, irq}, 2'b10);

        // R5: preload shows first bit and clears empty flag; R2 mode 0 exchange
        setup(8'h04, 8'h07);
        reg_wr(2'd1, 8'h5A);
        repeat (3) @(negedge clk);
        chk(miso == 1'b0, "R5 preload bit", miso, 0);
        reg_rd(2'd2, rv); chk(rv[0] == 1'b0, "R5 empty cleared", rv, 8'h00);
        exp_q.push_back(8'h3C);
        base = irq_cnt;
        xfer(8'h3C, 8, 1'b0, 1'b0, 1'b0, mrx);
        chk(mrx == 8'h5A, "R2 mode0 miso", mrx, 8'h5A);
        chk(mid_irq - base == 0 && irq_cnt - base == 1, "R6 done irq",
            irq_cnt - base, 1);
        reg_rd(2'd2, rv); chk(rv[0] == 1'b1, "R5 empty set", rv, 8'h03);
        check_rx("R2 mode0 rx");

        // R2: modes 1..3
        for (int m = 1; m < 4; m++) begin
            logic pol, pha;
            pol = m[1]; pha = m[0];
            setup({3'b000, pol, pha, 3'b100}, 8'h07);
            frame(stx3[m-1], mtx3[m-1], 8, pol, pha, 1'b0, mrx);
            chk(mrx == stx3[m-1], "R2 mode miso", mrx, stx3[m-1]);
            check_rx("R2 mode rx");
        end

        // R3: LSB first
        setup(8'h06, 8'h07);
        reg_wr(2'd1, 8'h1D);
        repeat (3) @(negedge clk);
        chk(miso == 1'b1, "R3 lsb first bit", miso, 1);
        exp_q.push_back(8'h8E);
        xfer(8'h8E, 8, 1'b0, 1'b0, 1'b1, mrx);
        chk(mrx == 8'h1D, "R3 lsb miso", mrx, 8'h1D);
        check_rx("R3 lsb rx");

        // R4: 7-bit frames, MSB then LSB first
        setup(8'h00, 8'h07);
        frame(8'hD3, 8'hFF, 7, 1'b0, 1'b0, 1'b0, mrx);
        chk(mrx == 8'h53, "R4 7bit msb miso", mrx, 8'h53);
        check_rx("R4 7bit msb rx");
        setup(8'h02, 8'h07);
        frame(8'h2C, 8'h95, 7, 1'b0, 1'b0, 1'b1, mrx);
        chk(mrx == 8'h2C, "R4 7bit lsb miso", mrx, 8'h2C);
        check_rx("R4 7bit lsb rx");

        // R6: buffer-empty interrupt at frame start
        setup(8'h05, 8'h07);
        base = irq_cnt;
        frame(8'h6B, 8'h44, 8, 1'b0, 1'b0, 1'b0, mrx);
        chk(mid_irq - base == 1, "R6 take irq early", mid_irq - base, 1);
        chk(irq_cnt - base == 1, "R6 take irq total", irq_cnt - base, 1);
        chk(mrx == 8'h6B, "R6 miso", mrx, 8'h6B);
        check_rx("R6 rx");

        // R7: underrun resends the previous byte
        setup(8'h04, 8'h07);
        xfer(8'h11, 8, 1'b0, 1'b0, 1'b0, mrx);
        chk(mrx == 8'h6B, "R7 resend", mrx, 8'h6B);
        reg_rd(2'd2, rv); chk(rv == 8'h0B, "R7 flag", rv, 8'h0B);
        reg_rd(2'd1, rv);
        reg_wr(2'd2, 8'h08);
        reg_rd(2'd2, rv); chk(rv == 8'h01, "R7 clear", rv, 8'h01);

        // R8: overrun replaces stored byte
        frame(8'h22, 8'h33, 8, 1'b0, 1'b0, 1'b0, mrx);
        frame(8'h44, 8'h55, 8, 1'b0, 1'b0, 1'b0, mrx);
        void'(exp_q.pop_front());
        reg_rd(2'd2, rv); chk(rv == 8'h07, "R8 flags", rv, 8'h07);
        check_rx("R8 overwrite");
        reg_wr(2'd2, 8'h04);
        reg_rd(2'd2, rv); chk(rv == 8'h01, "R8 clear", rv, 8'h01);

        // R9: output gated to the fixed level
        setup(8'h04, 8'h05);
        reg_wr(2'd1, 8'h00);
        oe_watch = 1'b1;
        xfer(8'h66, 8, 1'b0, 1'b0, 1'b0, mrx);
        oe_watch = 1'b0;
        chk(oe_bad == 0, "R9 level held", oe_bad, 0);
        reg_wr(2'd3, 8'h01);
        repeat (2) @(negedge clk);
        chk(miso == 1'b0, "R9 low level", miso, 0);
        reg_rd(2'd1, rv);

        // R10: stopped channel ignores the clock
        setup(8'h04, 8'h06);
        base = irq_cnt;
        xfer(8'hAA, 8, 1'b0, 1'b0, 1'b0, mrx);
        chk(irq_cnt == base, "R10 no irq", irq_cnt - base, 0);
        reg_rd(2'd2, rv); chk(rv[1] == 1'b0, "R10 no rx", rv, 8'h01);

        // R4: fixed-length variant keeps 8 bits
        setup(8'h00, 8'h07);
        reg_rd(2'd1, rv);
        xfer(8'h7F, 7, 1'b0, 1'b0, 1'b0, mrx);
        reg_rd(2'd2, rv);
        chk(rv[1] == 1'b1, "R4 select 7 done", rv, 8'h02);
        chk(rvf[1] == 1'b0, "R4 fixed not done", rvf, 8'h00);
        xfer(8'h01, 1, 1'b0, 1'b0, 1'b0, mrx);
        reg_rd(2'd2, rv);
        chk(rvf[1] == 1'b1, "R4 fixed done at 8", rvf, 8'h02);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule